// File: doc/BRIEF.md
# Expansion Bus Master Retry Sequencer

This block is the master side of a single-beat transfer on a shared expansion bus that has a wired-OR, active-low bus-error line. A client hands it one request over a valid/ready channel: an address, a direction and, for writes, a data word. The sequencer drives the address strobe and waits for the addressed slave to acknowledge. Read data is captured when the acknowledge arrives. The client then receives the data with a status code.

Any device on the bus may pull the error line low. While it is low, every output enable of the sequencer drops in the same cycle and the current attempt is abandoned. The first abort of a transfer is absorbed: the sequencer waits until it has seen the error line high at one clock edge and then reissues the cycle. If the reissued cycle is aborted as well, the sequencer stops trying, reports failure and raises a sticky notification that stays up until software clears it.

An attempt that gets neither an acknowledge nor an error is ended by a timeout counter and reported as a failure without a retry. The error count starts over with every transfer, so each new transfer again gets one retry.

Top module: `busRetryMaster`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0, errNotify is 0, and busAddrOe, busDataOe and busStrobeOe are all 0.
- R2: In the cycle after a request is accepted (reqValid and reqReady high at a clock edge), busStrobeN is 0 with busStrobeOe and busAddrOe at 1. busAddr holds the latched address and busWriteN is the inverse of reqWrite. busDataOe is 1 only for writes, and busWrData then holds the latched write data. Changes on the request inputs after acceptance have no effect.
- R3: An acknowledge (busAckN low at a clock edge during an attempt) ends the transfer. If no error occurred in the transfer, rspValid rises in the next cycle with rspStatus OK (encoded 2'd0). For a read, rspData holds the busRdData sampled at that edge.
- R4: Whenever busErrN is 0, busAddrOe, busDataOe and busStrobeOe are all 0 in that same cycle.
- R5: A first error sampled during an attempt aborts it. The bus stays released for as long as busErrN is low. The retry strobe is asserted in the cycle right after the first clock edge at which busErrN is sampled high.
- R6: An acknowledge on the retried attempt completes the transfer with rspStatus RETRIED_OK (encoded 2'd1).
- R7: An error on the retried attempt ends the transfer with rspStatus FAILED (encoded 2'd2) and starts no further attempt. errNotify is 1 from the next cycle.
- R8: errNotify stays 1 until errClear is sampled high while no new double error is being recorded. If a clear and a double error arrive in the same cycle, the flag stays set.
- R9: An attempt that sees neither an acknowledge nor an error keeps its strobe asserted for exactly TIMEOUT_CYCLES cycles. It then completes with rspStatus FAILED, without a retry and without changing errNotify.
- R10: The error count is cleared when a transfer finishes, so a transfer following any earlier outcome again receives one retry.
- R11: While the response is pending, reqReady is 0. rspValid and rspStatus stay unchanged until rspReady is sampled high. After that edge, rspValid is 0 and reqReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request accepted at this edge if valid |
| reqAddr | input | ADDR_W | Transfer address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWrData | input | DATA_W | Write data |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Client takes the response |
| rspStatus | output | 2 | 0 OK, 1 RETRIED_OK, 2 FAILED |
| rspData | output | DATA_W | Read data of a successful read |
| errNotify | output | 1 | Sticky flag for a double bus error |
| errClear | input | 1 | Clears errNotify |
| busAddr | output | ADDR_W | Address to the bus (with busWriteN) |
| busAddrOe | output | 1 | Enable for busAddr and busWriteN |
| busWrData | output | DATA_W | Write data to the bus |
| busDataOe | output | 1 | Enable for busWrData |
| busWriteN | output | 1 | Direction line, low for write |
| busStrobeN | output | 1 | Active-low address strobe |
| busStrobeOe | output | 1 | Enable for busStrobeN |
| busRdData | input | DATA_W | Read data from the bus |
| busAckN | input | 1 | Active-low slave acknowledge |
| busErrN | input | 1 | Active-low wired-OR bus error |

## Verification
Transfers are driven with each first-attempt outcome: acknowledge, error and silence until timeout. After a first error, the retry again meets each of those three outcomes. These cases separate OK from RETRIED_OK, and a double-error failure from a timeout failure, which differ in whether errNotify rises. Errors are held low for varying lengths, which shows that the retry strobe waits for the line to rise. Back-to-back retried transfers show that the count resets. A clear that arrives in the same cycle as a double error shows that setting the flag takes priority.

// File: rtl/busretry_pkg.sv
package busretry_pkg;

  typedef enum logic [1:0] {
    ST_OK         = 2'd0,
    ST_RETRIED_OK = 2'd1,
    ST_FAILED     = 2'd2
  } rspStatus_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ACTIVE,
    S_RECOVER,
    S_RESP
  } seqState_e;

  typedef struct packed {
    logic loadReq;
    logic driveBus;
    logic tmrClr;
    logic tmrRun;
    logic captureRd;
  } ctrlStrobes_t;

endpackage

// File: rtl/retryDatapath.sv
module retryDatapath
  import busretry_pkg::*;
#(
  parameter int ADDR_W         = 24,
  parameter int DATA_W         = 32,
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] busRdData,
  input  logic              busErrN,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busAddrOe,
  output logic [DATA_W-1:0] busWrData,
  output logic              busDataOe,
  output logic              busWriteN,
  output logic              busStrobeN,
  output logic              busStrobeOe,
  output logic [DATA_W-1:0] rspData,
  output logic              tmrExpired
);

  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wrDataReg;
  logic [DATA_W-1:0] rdDataReg;
  logic              writeReg;
  logic [TMR_W-1:0]  tmrCount;
  logic              busGate;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      wrDataReg <= '0;
      writeReg  <= 1'b0;
    end else if (strobes.loadReq) begin
      addrReg   <= reqAddr;
      wrDataReg <= reqWrData;
      writeReg  <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataReg <= '0;
    end else if (strobes.captureRd && !writeReg) begin
      rdDataReg <= busRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.tmrClr) begin
      tmrCount <= '0;
    end else if (strobes.tmrRun && !tmrExpired) begin
      tmrCount <= tmrCount + TMR_W'(1);
    end
  end

  assign tmrExpired = (tmrCount == TMR_LAST);

  // Bus error overrides every enable without waiting for a clock edge.
  assign busGate     = strobes.driveBus & busErrN;
  assign busAddr     = addrReg;
  assign busWrData   = wrDataReg;
  assign busWriteN   = ~writeReg;
  assign busStrobeN  = ~busGate;
  assign busAddrOe   = busGate;
  assign busStrobeOe = busGate;
  assign busDataOe   = busGate & writeReg;
  assign rspData     = rdDataReg;

  // R4: no enable while the shared error line is low
  a_r4_release_on_error : assert property (@(posedge clk) disable iff (!rstN)
    !busErrN |-> (!busAddrOe && !busStrobeOe && !busDataOe));

  // R9: attempt timer never passes its limit
  a_r9_timer_bound : assert property (@(posedge clk) disable iff (!rstN)
    tmrCount < TMR_W'(TIMEOUT_CYCLES));

  // R2: data enable only for a write cycle that drives the strobe
  a_r2_data_oe_write : assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> (busStrobeOe && !busWriteN));

endmodule

// File: rtl/retryCtrl.sv
module retryCtrl
  import busretry_pkg::*;
#(
  parameter int ERR_LIMIT = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         rspReady,
  input  logic         busAckN,
  input  logic         busErrN,
  input  logic         tmrExpired,
  input  logic         errClear,
  output logic         reqReady,
  output logic         rspValid,
  output logic [1:0]   rspStatus,
  output logic         errNotify,
  output ctrlStrobes_t strobes
);

  localparam int ERR_W = $clog2(ERR_LIMIT + 1);
  localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(ERR_LIMIT - 1);

  seqState_e        state, stateNext;
  rspStatus_e       statusReg, statusNext;
  logic [ERR_W-1:0] errCnt, errCntNext;
  logic             notifySet;

  always_comb begin
    stateNext  = state;
    statusNext = statusReg;
    errCntNext = errCnt;
    notifySet  = 1'b0;
    strobes    = '0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          strobes.loadReq = 1'b1;
          strobes.tmrClr  = 1'b1;
          errCntNext      = '0;
          stateNext       = S_ACTIVE;
        end
      end
      S_ACTIVE: begin
        strobes.driveBus = 1'b1;
        strobes.tmrRun   = 1'b1;
        if (!busErrN) begin
          if (errCnt == ERR_LAST) begin
            statusNext = ST_FAILED;
            notifySet  = 1'b1;
            errCntNext = '0;
            stateNext  = S_RESP;
          end else begin
            errCntNext = errCnt + ERR_W'(1);
            stateNext  = S_RECOVER;
          end
        end else if (!busAckN) begin
          strobes.captureRd = 1'b1;
          statusNext = (errCnt != '0) ? ST_RETRIED_OK : ST_OK;
          errCntNext = '0;
          stateNext  = S_RESP;
        end else if (tmrExpired) begin
          statusNext = ST_FAILED;
          errCntNext = '0;
          stateNext  = S_RESP;
        end
      end
      S_RECOVER: begin
        if (busErrN) begin
          strobes.tmrClr = 1'b1;
          stateNext      = S_ACTIVE;
        end
      end
      S_RESP: begin
        if (rspReady) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      statusReg <= ST_OK;
      errCnt    <= '0;
    end else begin
      state     <= stateNext;
      statusReg <= statusNext;
      errCnt    <= errCntNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          errNotify <= 1'b0;
    else if (notifySet) errNotify <= 1'b1;
    else if (errClear)  errNotify <= 1'b0;
  end

  assign reqReady  = (state == S_IDLE);
  assign rspValid  = (state == S_RESP);
  assign rspStatus = statusReg;

  // R5: no reissue while the error line is still low
  a_r5_hold_while_error : assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RECOVER && !busErrN) |=> (state == S_RECOVER));

  // R7: last tolerated error ends the transfer and raises the flag
  a_r7_give_up : assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACTIVE && !busErrN && errCnt == ERR_LAST)
      |=> (errNotify && rspValid && rspStatus == 2'd2));

  // R8: flag is sticky without a clear
  a_r8_notify_sticky : assert property (@(posedge clk) disable iff (!rstN)
    (errNotify && !errClear) |=> errNotify);

  // R11: response held until taken
  a_r11_rsp_hold : assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspStatus)));

  // R10: error count stays below the give-up limit
  a_r10_count_bound : assert property (@(posedge clk) disable iff (!rstN)
    errCnt < ERR_W'(ERR_LIMIT));

endmodule

// File: rtl/busRetryMaster.sv
module busRetryMaster
  import busretry_pkg::*;
#(
  parameter int ADDR_W         = 24,
  parameter int DATA_W         = 32,
  parameter int TIMEOUT_CYCLES = 16,
  parameter int ERR_LIMIT      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [1:0]        rspStatus,
  output logic [DATA_W-1:0] rspData,
  output logic              errNotify,
  input  logic              errClear,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busAddrOe,
  output logic [DATA_W-1:0] busWrData,
  output logic              busDataOe,
  output logic              busWriteN,
  output logic              busStrobeN,
  output logic              busStrobeOe,
  input  logic [DATA_W-1:0] busRdData,
  input  logic              busAckN,
  input  logic              busErrN
);

  ctrlStrobes_t strobes;
  logic         tmrExpired;

  retryCtrl #(.ERR_LIMIT(ERR_LIMIT)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .rspReady   (rspReady),
    .busAckN    (busAckN),
    .busErrN    (busErrN),
    .tmrExpired (tmrExpired),
    .errClear   (errClear),
    .reqReady   (reqReady),
    .rspValid   (rspValid),
    .rspStatus  (rspStatus),
    .errNotify  (errNotify),
    .strobes    (strobes)
  );

  retryDatapath #(
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqAddr     (reqAddr),
    .reqWrite    (reqWrite),
    .reqWrData   (reqWrData),
    .busRdData   (busRdData),
    .busErrN     (busErrN),
    .busAddr     (busAddr),
    .busAddrOe   (busAddrOe),
    .busWrData   (busWrData),
    .busDataOe   (busDataOe),
    .busWriteN   (busWriteN),
    .busStrobeN  (busStrobeN),
    .busStrobeOe (busStrobeOe),
    .rspData     (rspData),
    .tmrExpired  (tmrExpired)
  );

endmodule

// File: tb/sim_busRetryMaster.sv
module sim_busRetryMaster;

  localparam int AW  = 24;
  localparam int DW  = 32;
  localparam int TMO = 10;
  localparam int O_ACK = 0, O_ERR = 1, O_TMO = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, rspReady = 1'b0, errClear = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWrData = '0, busRdData = '0;
  logic busAckN = 1'b1, busErrN = 1'b1;
  logic reqReady, rspValid, errNotify, busAddrOe, busDataOe, busWriteN;
  logic busStrobeN, busStrobeOe;
  logic [1:0] rspStatus;
  logic [DW-1:0] rspData, busWrData;
  logic [AW-1:0] busAddr;

  int checks = 0;
  int fails = 0;
  bit notifyExp = 1'b0;
  bit clearWithErr = 1'b0;

  always #5 clk = ~clk;

  busRetryMaster #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYCLES(TMO), .ERR_LIMIT(2)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWrData(reqWrData),
    .rspValid(rspValid), .rspReady(rspReady), .rspStatus(rspStatus),
    .rspData(rspData), .errNotify(errNotify), .errClear(errClear),
    .busAddr(busAddr), .busAddrOe(busAddrOe), .busWrData(busWrData),
    .busDataOe(busDataOe), .busWriteN(busWriteN), .busStrobeN(busStrobeN),
    .busStrobeOe(busStrobeOe), .busRdData(busRdData), .busAckN(busAckN),
    .busErrN(busErrN)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] expStatus(input int o0, input int o1);
    if (o0 == O_ACK) return 2'd0;
    if (o0 == O_TMO) return 2'd2;
    if (o1 == O_ACK) return 2'd1;
    return 2'd2;
  endfunction

  function automatic bit strobeOn();
    return busStrobeOe && !busStrobeN && busAddrOe;
  endfunction

  function automatic bit allOff();
    return !busStrobeOe && !busAddrOe && !busDataOe;
  endfunction

  // Called at a negedge where an attempt is active; returns at a negedge.
  task automatic runAttempt(input int outc, input bit last, input logic [AW-1:0] a,
                            input bit wr, input logic [DW-1:0] wd, input logic [DW-1:0] rd);
    int delay = $urandom_range(0, 3);
    int hold  = $urandom_range(1, 4);
    if (outc == O_TMO) begin
      int seen = 0;
      for (int k = 0; k < TMO; k++) begin
        if (strobeOn()) seen++;
        @(negedge clk);
      end
      chk(seen == TMO, "R9", "strobe cycles before timeout", seen, TMO);
      chk(!strobeOn(), "R9", "strobe after timeout", strobeOn(), 0);
      return;
    end
    for (int k = 0; k < delay; k++) begin
      chk(strobeOn() && busAddr == a, "R2", "attempt addr", busAddr, a);
      @(negedge clk);
    end
    chk(busWriteN == !wr && busDataOe == wr, "R2", "direction/data enable",
        {busWriteN, busDataOe}, {!wr, wr});
    if (wr) chk(busWrData == wd, "R2", "write data", busWrData, wd);
    if (outc == O_ACK) begin
      busAckN = 1'b0;
      busRdData = rd;
      @(negedge clk);
      busAckN = 1'b1;
      busRdData = $urandom();
      return;
    end
    busErrN = 1'b0;
    if (last && clearWithErr) errClear = 1'b1;
    #1;
    chk(allOff(), "R4", "enables with error low", {busStrobeOe, busAddrOe, busDataOe}, 0);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      errClear = 1'b0;
      chk(allOff(), "R5", "bus released while error low",
          {busStrobeOe, busAddrOe, busDataOe}, 0);
    end
    busErrN = 1'b1;
    #1;
    chk(!strobeOn(), "R5", "no strobe before error seen high", strobeOn(), 0);
    @(negedge clk);
    if (!last) chk(strobeOn(), "R5", "retry strobe after error rise", strobeOn(), 1);
    else       chk(!strobeOn(), "R7", "no attempt after second error", strobeOn(), 0);
  endtask

  task automatic doXfer(input int o0, input int o1);
    logic [AW-1:0] a  = AW'($urandom());
    logic [DW-1:0] wd = $urandom();
    logic [DW-1:0] rd = $urandom();
    bit wr = 1'($urandom_range(0, 1));
    logic [1:0] es = expStatus(o0, o1);
    int waitR = $urandom_range(0, 3);
    chk(reqReady, "R11", "ready before request", reqReady, 1);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqWrData = wd;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqWrite = ~wr; reqWrData = ~wd;
    chk(!reqReady, "R11", "busy after accept", reqReady, 0);
    chk(strobeOn() && busAddr == a, "R2", "strobe and latched addr", busAddr, a);
    runAttempt(o0, 1'b0, a, wr, wd, rd);
    if (o0 == O_ERR) runAttempt(o1, 1'b1, a, wr, wd, rd);
    if (o0 == O_ERR && o1 == O_ERR) notifyExp = 1'b1;
    chk(rspValid, "R11", "response valid", rspValid, 1);
    if (es == 2'd0)      chk(rspStatus == es, "R3", "status", rspStatus, es);
    else if (es == 2'd1) chk(rspStatus == es, "R6", "status", rspStatus, es);
    else if (o0 == O_TMO || o1 == O_TMO) chk(rspStatus == es, "R9", "status", rspStatus, es);
    else                 chk(rspStatus == es, "R7", "status", rspStatus, es);
    if (!wr && es != 2'd2) chk(rspData == rd, "R3", "read data", rspData, rd);
    chk(errNotify == notifyExp, "R8", "notify flag", errNotify, notifyExp);
    for (int k = 0; k < waitR; k++) begin
      @(negedge clk);
      chk(rspValid && rspStatus == es && allOff(), "R11", "held response",
          {rspValid, rspStatus}, {1'b1, es});
    end
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(!rspValid && reqReady, "R11", "after take", {rspValid, reqReady}, 2'b01);
    if ($urandom_range(0, 3) == 0) begin
      errClear = 1'b1;
      @(negedge clk);
      errClear = 1'b0;
      notifyExp = 1'b0;
      chk(!errNotify, "R8", "clear", errNotify, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd7321);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid && !errNotify && allOff(), "R1", "reset state",
        {reqReady, rspValid, errNotify, busStrobeOe, busAddrOe, busDataOe}, 6'b100000);
    // Directed corners
    doXfer(O_ACK, O_ACK);
    doXfer(O_ERR, O_ACK);
    doXfer(O_ERR, O_ACK);   // R10: count reset, second transfer retried again
    doXfer(O_TMO, O_ACK);
    doXfer(O_ERR, O_TMO);
    doXfer(O_ERR, O_ERR);   // R7
    chk(errNotify, "R8", "sticky across idle", errNotify, 1);
    errClear = 1'b1; @(negedge clk); errClear = 1'b0; notifyExp = 1'b0;
    chk(!errNotify, "R8", "cleared", errNotify, 0);
    clearWithErr = 1'b1;
    doXfer(O_ERR, O_ERR);   // R8: set wins over clear
    clearWithErr = 1'b0;
    doXfer(O_ERR, O_ACK);   // R10 after a give-up
    // Random mix
    for (int i = 0; i < 80; i++) begin
      int o0 = $urandom_range(0, 2);
      int o1 = $urandom_range(0, 2);
      doXfer(o0, o1);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule